// File: doc/BRIEF.md
# Buffered Serial Port with Register Interface

This block is an asynchronous serial transceiver with 8-N-1 framing that a host drives through five byte-wide registers. A single transmit holding stage serialises one byte at a time and shows its progress in a status bit. A 31-entry receive queue collects incoming bytes, and its fill level is shown in a counter that the host can both read and overwrite. The bit rate comes from the system clock through a divider. Seven preset codes select rates from 9600 down to 150 baud, and a separate enable switches to one of two high rates.

The host reads the counter to learn how many bytes are waiting and pops them one at a time through the data register. Once 31 bytes are held the counter stops at 1Fh, which the host treats as an overflow mark. Later bytes are lost until the host writes the counter again, usually with zero to flush the queue. Frames are sent least significant bit first and the line idles high. The receiver oversamples at sixteen times the bit rate and takes each bit near its middle.

Top module: `buffered_uart`

## Requirements
- R1: After reset, a read of address 0 returns 01h, a read of address 2 (count) returns 00h, `txOut` is 1, high-rate mode is off and the rate code is 0.
- R2: Writing a value N from 0 to 6 to address 0 selects the rate 9600/2^N baud. A bit then lasts 16*D system cycles, where D = max(1, (CLK_HZ + 8*baud) / (16*baud)) in integer division. Writing a value of 7 or more to address 0 leaves the rate unchanged.
- R3: Bit 0 of address 0 reads 0 while a frame is being sent. It reads 1 again from the end of the stop bit.
- R4: A data write (address 1) to an idle transmitter drives `txOut` low in the cycle after the write. The line then carries a start bit (0), data bits 0 to 7, and a stop bit (1), each lasting one bit time.
- R5: A data write while a frame is in flight is ignored. The current frame is unchanged and no further frame follows it.
- R6: The receiver takes a frame of one low start bit, 8 data bits LSB first and one stop bit. A frame with a high stop bit is queued and the count rises by one. A frame whose stop bit is low is discarded and the count is unchanged.
- R7: A read of address 1 returns the oldest queued byte, removes it and lowers the count by one. A read with the count at 0 leaves the count at 0.
- R8: The count saturates at 1Fh when 31 bytes are held. A byte arriving at that point is dropped and sets a lock. While the lock is set, every received byte is dropped, even after pops. A write to the count register clears the lock.
- R9: Writing address 2 loads bits 4:0 of the data into the count and keeps the oldest byte in place. Writing 0 empties the queue, and the next received byte is the next one read.
- R10: Bit 0 written to address 3 enables high-rate mode. In that mode, A5h written to address 4 selects D for 57600 baud and 51h selects D for 115200 baud (same formula as R2). The reset selection is A5h. Other values written to address 4 are ignored. Clearing address 3 returns to the preset-code rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address: 0 config/status, 1 data, 2 count, 3 high-rate enable, 4 high-rate select |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regRdEn | input | 1 | Register read strobe; pops the queue when the address is 1 |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| txOut | output | 1 | Serial transmit line, idles high |
| rxIn | input | 1 | Serial receive line, asynchronous |

## Verification
The hardest state to reach from the ports is the overflow lock. It needs 31 well-formed frames, then one more, then a pop, and then a further frame that must still be dropped. The stimulus reaches it quickly by switching to high-rate mode so that each frame takes only a few hundred cycles. The rate sweep is the other costly part: at the slowest code a full frame would take too long. For that reason each code is checked by measuring only the width of its start bit, with a reset between codes.

// File: rtl/buart_pkg.sv
package buart_pkg;

  localparam logic [2:0] ADDR_CFG   = 3'd0;
  localparam logic [2:0] ADDR_DATA  = 3'd1;
  localparam logic [2:0] ADDR_COUNT = 3'd2;
  localparam logic [2:0] ADDR_HSEN  = 3'd3;
  localparam logic [2:0] ADDR_HSSEL = 3'd4;

  localparam logic [7:0] HS_CODE_MID  = 8'hA5;
  localparam logic [7:0] HS_CODE_FAST = 8'h51;

  // strobes passed from register decode to the datapath
  typedef struct packed {
    logic       txLoad;
    logic       rxPop;
    logic       cntLoad;
    logic [7:0] wrByte;
  } hostStrobe_t;

  // clock cycles per oversample tick, rounded, never below one
  function automatic int unsigned roundDiv(int unsigned clkHz, int unsigned baud);
    int unsigned d;
    d = (clkHz + 8 * baud) / (16 * baud);
    if (d == 0) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/buart_ctrl.sv
module buart_ctrl
  import buart_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned BASE_BAUD = 9600,
  parameter int unsigned NUM_RATES = 7,
  parameter int unsigned MID_BAUD  = 57600,
  parameter int unsigned FAST_BAUD = 115200,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              txBusy,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [7:0]        rxHead,
  output hostStrobe_t       strobe,
  output logic [DIV_W-1:0]  divisor
);

  localparam int unsigned RATE_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;

  logic [RATE_W-1:0] rateCode;
  logic              hsEnable;
  logic              hsFast;

  logic [DIV_W-1:0] slowDiv [NUM_RATES];
  logic [DIV_W-1:0] midDiv;
  logic [DIV_W-1:0] fastDiv;

  for (genvar g = 0; g < NUM_RATES; g++) begin : gSlowDiv
    assign slowDiv[g] = DIV_W'(roundDiv(CLK_HZ, BASE_BAUD >> g));
  end
  assign midDiv  = DIV_W'(roundDiv(CLK_HZ, MID_BAUD));
  assign fastDiv = DIV_W'(roundDiv(CLK_HZ, FAST_BAUD));

  logic cfgWrite, hsEnWrite, hsSelWrite;
  assign cfgWrite   = regWrEn && (regAddr == ADDR_CFG);
  assign hsEnWrite  = regWrEn && (regAddr == ADDR_HSEN);
  assign hsSelWrite = regWrEn && (regAddr == ADDR_HSSEL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCode <= '0;
      hsEnable <= 1'b0;
      hsFast   <= 1'b0;
    end else begin
      if (cfgWrite && (regWrData < 8'(NUM_RATES)))
        rateCode <= regWrData[RATE_W-1:0];
      if (hsEnWrite)
        hsEnable <= regWrData[0];
      if (hsSelWrite) begin
        if (regWrData == HS_CODE_MID)       hsFast <= 1'b0;
        else if (regWrData == HS_CODE_FAST) hsFast <= 1'b1;
      end
    end
  end

  always_comb begin
    if (hsEnable) divisor = hsFast ? fastDiv : midDiv;
    else          divisor = slowDiv[rateCode];
  end

  always_comb begin
    strobe.txLoad  = regWrEn && (regAddr == ADDR_DATA);
    strobe.rxPop   = regRdEn && (regAddr == ADDR_DATA);
    strobe.cntLoad = regWrEn && (regAddr == ADDR_COUNT);
    strobe.wrByte  = regWrData;
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG:   regRdData = {7'b0, ~txBusy};
      ADDR_DATA:  regRdData = rxHead;
      ADDR_COUNT: regRdData = 8'(rxCount);
      default:    regRdData = 8'h00;
    endcase
  end

  // R2: an out-of-range preset code leaves the bit timing alone
  a_r2_bad_code_ignored: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && (regWrData >= 8'(NUM_RATES)) |=> $stable(divisor));

  // R10: an unknown high-rate select value leaves the bit timing alone
  a_r10_bad_select_ignored: assert property (@(posedge clk) disable iff (!rstN)
    hsSelWrite && (regWrData != HS_CODE_MID) && (regWrData != HS_CODE_FAST)
    |=> $stable(divisor));

endmodule

// File: rtl/buart_datapath.sv
module buart_datapath
  import buart_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DEPTH = 31,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       st,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              rxIn,
  output logic              txOut,
  output logic              txBusy,
  output logic [CNT_W-1:0]  rxCount,
  output logic [7:0]        rxHead
);

  localparam int unsigned BIT_W = DIV_W + 4;

  // ---------------- oversample tick for the receiver ----------------
  logic [DIV_W-1:0] ovCnt;
  logic             ovTick;
  assign ovTick = (ovCnt >= divisor - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)       ovCnt <= '0;
    else if (ovTick) ovCnt <= '0;
    else             ovCnt <= ovCnt + DIV_W'(1);
  end

  // ---------------- transmitter ----------------
  logic [BIT_W-1:0] bitLen;
  logic [BIT_W-1:0] txTimer;
  logic [9:0]       txShift;
  logic [3:0]       txBitIdx;
  logic             txBitEnd;

  assign bitLen   = {divisor, 4'b0000};
  assign txBitEnd = (txTimer >= bitLen - BIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txShift  <= '1;
      txTimer  <= '0;
      txBitIdx <= '0;
    end else if (!txBusy) begin
      if (st.txLoad) begin
        txBusy   <= 1'b1;
        txShift  <= {1'b1, st.wrByte, 1'b0};
        txTimer  <= '0;
        txBitIdx <= '0;
      end
    end else if (txBitEnd) begin
      txTimer <= '0;
      txShift <= {1'b1, txShift[9:1]};
      if (txBitIdx == 4'd9) txBusy <= 1'b0;
      else                  txBitIdx <= txBitIdx + 4'd1;
    end else begin
      txTimer <= txTimer + BIT_W'(1);
    end
  end

  assign txOut = txBusy ? txShift[0] : 1'b1;

  // ---------------- receiver ----------------
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rxState_t;

  rxState_t   rxState;
  logic       rxMeta, rxLine;
  logic [3:0] rxTicks;
  logic [2:0] rxBitIdx;
  logic [7:0] rxShift;
  logic       rxPush;

  assign rxPush = (rxState == RX_STOP) && ovTick && (rxTicks == 4'd15) && rxLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxLine <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxLine <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxTicks  <= '0;
      rxBitIdx <= '0;
      rxShift  <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          rxTicks <= '0;
          if (!rxLine) rxState <= RX_START;
        end
        RX_START: if (ovTick) begin
          if (rxTicks == 4'd7) begin
            rxTicks  <= '0;
            rxBitIdx <= '0;
            rxState  <= rxLine ? RX_IDLE : RX_DATA;
          end else begin
            rxTicks <= rxTicks + 4'd1;
          end
        end
        RX_DATA: if (ovTick) begin
          rxTicks <= rxTicks + 4'd1;
          if (rxTicks == 4'd15) begin
            rxShift  <= {rxLine, rxShift[7:1]};
            rxBitIdx <= rxBitIdx + 3'd1;
            if (rxBitIdx == 3'd7) rxState <= RX_STOP;
          end
        end
        RX_STOP: if (ovTick) begin
          rxTicks <= rxTicks + 4'd1;
          if (rxTicks == 4'd15) rxState <= rxLine ? RX_IDLE : RX_BREAK;
        end
        RX_BREAK: if (rxLine) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- receive queue and counter ----------------
  logic [7:0]       qMem [DEPTH];
  logic [CNT_W-1:0] rdPtr;
  logic [CNT_W-1:0] wrIdx;
  logic [CNT_W:0]   idxSum;
  logic             ovfLock;
  logic             canPush, doPop;

  assign idxSum  = {1'b0, rdPtr} + {1'b0, rxCount};
  assign wrIdx   = (idxSum >= (CNT_W+1)'(DEPTH)) ? CNT_W'(idxSum - (CNT_W+1)'(DEPTH))
                                                 : CNT_W'(idxSum);
  assign canPush = rxPush && !ovfLock && (rxCount != CNT_W'(DEPTH));
  assign doPop   = st.rxPop && (rxCount != '0);

  always_ff @(posedge clk) begin
    if (canPush && !st.cntLoad) qMem[wrIdx] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      rxCount <= '0;
      ovfLock <= 1'b0;
    end else if (st.cntLoad) begin
      ovfLock <= 1'b0;
      if (st.wrByte[CNT_W-1:0] > CNT_W'(DEPTH)) rxCount <= CNT_W'(DEPTH);
      else                                      rxCount <= st.wrByte[CNT_W-1:0];
    end else begin
      rxCount <= rxCount + CNT_W'(canPush) - CNT_W'(doPop);
      if (rxPush && !canPush) ovfLock <= 1'b1;
      if (doPop) rdPtr <= (rdPtr == CNT_W'(DEPTH - 1)) ? '0 : rdPtr + CNT_W'(1);
    end
  end

  assign rxHead = qMem[rdPtr];

  // ---------------- checks ----------------
  // R4: accepted write starts the start bit next cycle
  a_r4_start_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy && st.txLoad |=> txBusy && !txOut);

  // R4: the last bit before going idle is a high stop bit
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> $past(txOut));

  // R3: busy is only entered through a data write
  a_r3_busy_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(st.txLoad));

  // R5: a write during a frame does not disturb it
  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    txBusy && st.txLoad && !txBitEnd |=> $stable(txShift) && $stable(txBitIdx));

  // R6: a good frame adds one byte when room remains
  a_r6_push_counts: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && !ovfLock && (rxCount != CNT_W'(DEPTH)) && !st.cntLoad && !st.rxPop
    |=> rxCount == $past(rxCount) + CNT_W'(1));

  // R7: a pop lowers the count by one
  a_r7_pop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    st.rxPop && (rxCount != '0) && !rxPush && !st.cntLoad
    |=> rxCount == $past(rxCount) - CNT_W'(1));

  // R8: the count never passes the queue depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  // R8: while locked, nothing raises the count
  a_r8_locked_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    ovfLock && !st.cntLoad |=> rxCount <= $past(rxCount));

  // R9: a count write lands as written
  a_r9_count_load: assert property (@(posedge clk) disable iff (!rstN)
    st.cntLoad && (st.wrByte[CNT_W-1:0] <= CNT_W'(DEPTH))
    |=> rxCount == $past(st.wrByte[CNT_W-1:0]));

endmodule

// File: rtl/buffered_uart.sv
module buffered_uart
  import buart_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned BASE_BAUD  = 9600,
  parameter int unsigned NUM_RATES  = 7,
  parameter int unsigned MID_BAUD   = 57600,
  parameter int unsigned FAST_BAUD  = 115200,
  parameter int unsigned FIFO_DEPTH = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       txOut,
  input  logic       rxIn
);

  localparam int unsigned SLOW_DIV = roundDiv(CLK_HZ, BASE_BAUD >> (NUM_RATES - 1));
  localparam int unsigned DIV_W    = $clog2(SLOW_DIV + 1);
  localparam int unsigned CNT_W    = $clog2(FIFO_DEPTH + 1);

  hostStrobe_t      strobe;
  logic [DIV_W-1:0] divisor;
  logic             txBusy;
  logic [CNT_W-1:0] rxCount;
  logic [7:0]       rxHead;

  buart_ctrl #(
    .CLK_HZ(CLK_HZ), .BASE_BAUD(BASE_BAUD), .NUM_RATES(NUM_RATES),
    .MID_BAUD(MID_BAUD), .FAST_BAUD(FAST_BAUD), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .txBusy(txBusy), .rxCount(rxCount), .rxHead(rxHead),
    .strobe(strobe), .divisor(divisor)
  );

  buart_datapath #(
    .DIV_W(DIV_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .st(strobe), .divisor(divisor), .rxIn(rxIn),
    .txOut(txOut), .txBusy(txBusy), .rxCount(rxCount), .rxHead(rxHead)
  );

endmodule

// File: tb/tb_buffered_uart.sv
`timescale 1ns/1ps
module tb_buffered_uart;

  localparam int unsigned CLK_HZ = 2_000_000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       txOut;
  logic       rxIn = 1'b1;

  int nVec = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  buffered_uart #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .txOut(txOut), .rxIn(rxIn)
  );

  function automatic int bitCycles(int baud);
    int d;
    d = (CLK_HZ + 8 * baud) / (16 * baud);
    if (d < 1) d = 1;
    return 16 * d;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; rxIn = 1'b1;
    waitCyc(3);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic measureStart(output int n);
    n = 0;
    while (txOut === 1'b0 && n < 50000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // samples the ten bit centres; startK = cycles already elapsed since load
  task automatic checkFrame(input logic [7:0] b, input int bitCyc, input int startK,
                            input string tag);
    for (int i = 0; i < 10; i++) begin
      logic expBit;
      waitCyc(i == 0 ? bitCyc / 2 - startK : bitCyc);
      expBit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      check(txOut === expBit, tag, txOut, expBit);
    end
  endtask

  task automatic rxSend(input logic [7:0] b, input int bitCyc, input bit goodStop);
    @(negedge clk);
    rxIn = 1'b0; waitCyc(bitCyc);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i]; waitCyc(bitCyc);
    end
    rxIn = goodStop; waitCyc(bitCyc);
    rxIn = 1'b1; waitCyc(bitCyc);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    int hsBit;
    logic [7:0] seq [33];

    doReset();
    // R1: reset state
    regRead(3'd0, v); check(v === 8'h01, "R1 status", v, 8'h01);
    regRead(3'd2, v); check(v === 8'h00, "R1 count", v, 8'h00);
    check(txOut === 1'b1, "R1 txOut idle", txOut, 1);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(9600), "R1 default rate", n, bitCycles(9600));

    // R2: every preset code, start-bit width only
    for (int c = 0; c < 7; c++) begin
      doReset();
      regWrite(3'd0, 8'(c));
      regWrite(3'd1, 8'h55);
      measureStart(n);
      check(n == bitCycles(9600 >> c), $sformatf("R2 code %0d", c), n, bitCycles(9600 >> c));
    end
    doReset();
    regWrite(3'd0, 8'd1);
    regWrite(3'd0, 8'd7);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(4800), "R2 code 7 ignored", n, bitCycles(4800));
    doReset();
    regWrite(3'd0, 8'd2);
    regWrite(3'd0, 8'hF3);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(2400), "R2 code F3 ignored", n, bitCycles(2400));

    // R4 and R3: full frame at 9600
    doReset();
    regWrite(3'd1, 8'hA6);
    checkFrame(8'hA6, bitCycles(9600), 0, "R4 frame A6");
    regRead(3'd0, v); check(v === 8'h00, "R3 busy in stop bit", v, 8'h00);
    waitCyc(bitCycles(9600));
    regRead(3'd0, v); check(v === 8'h01, "R3 done after stop", v, 8'h01);

    // R10: high-rate selection
    doReset();
    regWrite(3'd3, 8'h01);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(57600), "R10 default A5 rate", n, bitCycles(57600));
    waitCyc(10 * bitCycles(57600));
    regWrite(3'd4, 8'h51);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(115200), "R10 51h rate", n, bitCycles(115200));
    waitCyc(10 * bitCycles(115200));
    regWrite(3'd4, 8'h33);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(115200), "R10 bad select ignored", n, bitCycles(115200));
    waitCyc(10 * bitCycles(115200));
    regWrite(3'd4, 8'hA5);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(57600), "R10 A5h rate", n, bitCycles(57600));
    waitCyc(10 * bitCycles(57600));
    regWrite(3'd3, 8'h00);
    regWrite(3'd1, 8'h55); measureStart(n);
    check(n == bitCycles(9600), "R10 disable restores code", n, bitCycles(9600));

    // R5: write while busy, in high-rate mode
    doReset();
    regWrite(3'd3, 8'h01);
    hsBit = bitCycles(57600);
    regWrite(3'd1, 8'h3C);
    regWrite(3'd1, 8'hC3);
    checkFrame(8'h3C, hsBit, 1, "R5 frame kept");
    waitCyc(hsBit);
    n = 0;
    for (int i = 0; i < 3 * hsBit; i++) begin
      if (txOut !== 1'b1) n++;
      @(negedge clk);
    end
    check(n == 0, "R5 no second frame", n, 0);

    // R6 and R7: receive, order, bad stop
    rxSend(8'h11, hsBit, 1'b1);
    rxSend(8'h22, hsBit, 1'b1);
    rxSend(8'h33, hsBit, 1'b1);
    regRead(3'd2, v); check(v === 8'd3, "R6 count after 3", v, 3);
    rxSend(8'h44, hsBit, 1'b0);
    regRead(3'd2, v); check(v === 8'd3, "R6 bad stop discarded", v, 3);
    regRead(3'd1, v); check(v === 8'h11, "R7 first", v, 8'h11);
    regRead(3'd2, v); check(v === 8'd2, "R7 count 2", v, 2);
    regRead(3'd1, v); check(v === 8'h22, "R7 second", v, 8'h22);
    regRead(3'd1, v); check(v === 8'h33, "R7 third", v, 8'h33);
    regRead(3'd2, v); check(v === 8'd0, "R7 count 0", v, 0);
    regRead(3'd1, v);
    regRead(3'd2, v); check(v === 8'd0, "R7 pop on empty", v, 0);

    // R8: saturation and lock
    for (int i = 0; i < 33; i++) seq[i] = 8'((i * 37 + 5) & 8'hFF);
    for (int i = 0; i < 31; i++) rxSend(seq[i], hsBit, 1'b1);
    regRead(3'd2, v); check(v === 8'h1F, "R8 full at 1F", v, 8'h1F);
    rxSend(seq[31], hsBit, 1'b1);
    regRead(3'd2, v); check(v === 8'h1F, "R8 saturated", v, 8'h1F);
    regRead(3'd1, v); check(v === seq[0], "R8 oldest kept", v, seq[0]);
    regRead(3'd2, v); check(v === 8'h1E, "R8 after pop", v, 8'h1E);
    rxSend(seq[32], hsBit, 1'b1);
    regRead(3'd2, v); check(v === 8'h1E, "R8 locked drop", v, 8'h1E);
    for (int i = 1; i < 31; i++) begin
      regRead(3'd1, v); check(v === seq[i], "R8 queue order", v, seq[i]);
    end

    // R9: count writes
    regWrite(3'd2, 8'h00);
    regRead(3'd2, v); check(v === 8'h00, "R9 clear", v, 0);
    rxSend(8'h5A, hsBit, 1'b1);
    regRead(3'd2, v); check(v === 8'h01, "R9 lock cleared", v, 1);
    regRead(3'd1, v); check(v === 8'h5A, "R9 next byte read", v, 8'h5A);
    rxSend(8'hA1, hsBit, 1'b1);
    rxSend(8'hB2, hsBit, 1'b1);
    rxSend(8'hC3, hsBit, 1'b1);
    regWrite(3'd2, 8'h01);
    regRead(3'd2, v); check(v === 8'h01, "R9 partial load", v, 1);
    regRead(3'd1, v); check(v === 8'hA1, "R9 oldest after load", v, 8'hA1);
    regRead(3'd2, v); check(v === 8'h00, "R9 empty after pop", v, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule